// File: doc/BRIEF.md
# Stuck Interrupt Source Detector

This block watches a stream of accepted interrupt messages. Each message carries the requester's bus/device/function number and a cause code. The block stores every accepted message in a circular history, together with the value of a free-running time counter at the moment it was accepted.

When a new message arrives and the history is full, the block compares the new message with the oldest entry it still holds. That is the message accepted DEPTH messages earlier. A source is judged stuck when both of these hold:
- the two messages are identical;
- the new message arrived within a programmable number of time units of the old one.

In other words, a single source has been filling the whole history at a rate the system cannot plausibly want.

On a detection the block gives three outputs:
- a single-cycle pulse;
- a copy of the offending message, held until the next detection;
- a sticky flag, which stays set until software clears it.

What to do with the stuck source is left to the surrounding logic.

Top module: `irq_stuck_watch`

## Requirements
- R1: After reset, stuck_pulse_o, stuck_sticky_o, stuck_src_o and stuck_cause_o are all zero and the history holds no entries.
- R2: The history has DEPTH (default 16) slots. No detection is possible until DEPTH messages have been accepted since reset. The first DEPTH messages never raise the pulse, even when they are identical and arrive back to back.
- R3: Once the history is full, each accepted message is compared with the entry accepted DEPTH messages earlier, and then overwrites it. Two messages match only when the 16-bit source field and the 8-bit cause field are both equal.
- R4: A match counts as stuck only when (new time − old time) is strictly less than the threshold. A gap equal to the threshold is not stuck.
- R5: The time gap is computed as unsigned subtraction modulo 2^TS_W. A counter wrap between the two messages still gives the true elapsed time.
- R6: A detection raises stuck_pulse_o for exactly the one cycle after the edge that accepted the message. At the same edge, stuck_src_o and stuck_cause_o take the offending message's fields.
- R7: stuck_sticky_o is set by every detection and stays set until stuck_clr_i is sampled high. A detection in the same cycle as a clear leaves it set.
- R8: The threshold register loads thr_data_i on each edge where thr_we_i is high, and resets to THR_RST (default 1024). A threshold of zero disables detection.
- R9: Cycles with msg_valid_i low store nothing and advance nothing, whatever the other message inputs carry.
- R10: stuck_src_o and stuck_cause_o hold their value until the next detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_valid_i | input | 1 | An interrupt message is accepted this cycle |
| msg_src_i | input | 16 | Bus/device/function of the requester |
| msg_cause_i | input | 8 | Cause code of the message |
| time_i | input | TS_W | Free-running time counter |
| thr_we_i | input | 1 | Load the gap threshold |
| thr_data_i | input | TS_W | New gap threshold |
| stuck_clr_i | input | 1 | Clear the sticky stuck flag |
| stuck_pulse_o | output | 1 | One-cycle stuck detection pulse |
| stuck_src_o | output | 16 | Source field of the last stuck message |
| stuck_cause_o | output | 8 | Cause field of the last stuck message |
| stuck_sticky_o | output | 1 | Sticky stuck flag |

## Verification
The bench sends 16 identical messages packed close together. A design that checks before the history is full would pulse on the second message.

It places a gap exactly on the threshold and one just under it. An off-by-one comparison accepts the first or misses the second.

It fills the history with timestamps just below the counter wrap. A design that subtracts with signed or widened arithmetic either misses the real short gap or flags a long one.

It also checks the following:
- Messages that differ only in source or only in cause. A design comparing one field alone flags these wrongly.
- Idle cycles with garbage on the message inputs. A design that records them shifts the history.
- A clear that coincides with a detection. A design that lets the clear win loses a real event.

// File: rtl/irq_stuck_pkg.sv
package irq_stuck_pkg;

   localparam int SRC_W   = 16;
   localparam int CAUSE_W = 8;

   typedef struct packed {
      logic [SRC_W-1:0]   src;
      logic [CAUSE_W-1:0] cause;
   } irq_msg_t;

endpackage

// File: rtl/irq_hist_ring.sv
module irq_hist_ring
   import irq_stuck_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int TS_W  = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_en_i,
   input  irq_msg_t        wr_msg_i,
   input  logic [TS_W-1:0] wr_ts_i,
   output irq_msg_t        old_msg_o,
   output logic [TS_W-1:0] old_ts_o,
   output logic            full_o
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   irq_msg_t        msg_q [DEPTH];
   logic [TS_W-1:0] ts_q  [DEPTH];
   logic [PW-1:0]   ptr_q;
   logic [PW-1:0]   ptr_nxt;
   logic            full_q;

   if (DEPTH < 2) begin : g_bad_depth
      $error("irq_hist_ring: DEPTH must be at least 2");
   end

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_mod
      assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         msg_q[ptr_q] <= wr_msg_i;
         ts_q[ptr_q]  <= wr_ts_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q  <= '0;
         full_q <= 1'b0;
      end else if (wr_en_i) begin
         ptr_q <= ptr_nxt;
         if (ptr_q == LAST) full_q <= 1'b1;
      end
   end

   assign old_msg_o = msg_q[ptr_q];
   assign old_ts_o  = ts_q[ptr_q];
   assign full_o    = full_q;

   AST_FULL_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_q |=> full_q); // R2
   AST_PTR_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (ptr_q != $past(ptr_q))); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(ptr_q)); // R9

endmodule

// File: rtl/irq_stuck_judge.sv
module irq_stuck_judge
   import irq_stuck_pkg::*;
#(
   parameter int TS_W = 32
) (
   input  logic            valid_i,
   input  logic            full_i,
   input  irq_msg_t        new_msg_i,
   input  logic [TS_W-1:0] new_ts_i,
   input  irq_msg_t        old_msg_i,
   input  logic [TS_W-1:0] old_ts_i,
   input  logic [TS_W-1:0] thresh_i,
   output logic            hit_o
);

   logic [TS_W-1:0] gap;
   logic            same;

   // modulo 2^TS_W difference is the true elapsed time across one wrap
   assign gap   = new_ts_i - old_ts_i;
   assign same  = (new_msg_i.src == old_msg_i.src) &&
                  (new_msg_i.cause == old_msg_i.cause);
   assign hit_o = valid_i && full_i && same && (gap < thresh_i);

endmodule

// File: rtl/irq_stuck_watch.sv
module irq_stuck_watch
   import irq_stuck_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int TS_W  = 32,
   parameter logic [TS_W-1:0] THR_RST = 1024
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               msg_valid_i,
   input  logic [SRC_W-1:0]   msg_src_i,
   input  logic [CAUSE_W-1:0] msg_cause_i,
   input  logic [TS_W-1:0]    time_i,
   input  logic               thr_we_i,
   input  logic [TS_W-1:0]    thr_data_i,
   input  logic               stuck_clr_i,
   output logic               stuck_pulse_o,
   output logic [SRC_W-1:0]   stuck_src_o,
   output logic [CAUSE_W-1:0] stuck_cause_o,
   output logic               stuck_sticky_o
);

   if (TS_W < 2) begin : g_bad_ts
      $error("irq_stuck_watch: TS_W must be at least 2");
   end

   irq_msg_t        in_msg;
   irq_msg_t        old_msg;
   logic [TS_W-1:0] old_ts;
   logic            hist_full;
   logic            hit;
   logic [TS_W-1:0] thresh_q;
   logic            pulse_q;
   logic            sticky_q;
   irq_msg_t        latch_q;

   assign in_msg.src   = msg_src_i;
   assign in_msg.cause = msg_cause_i;

   irq_hist_ring #(.DEPTH(DEPTH), .TS_W(TS_W)) u_ring (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (msg_valid_i),
      .wr_msg_i  (in_msg),
      .wr_ts_i   (time_i),
      .old_msg_o (old_msg),
      .old_ts_o  (old_ts),
      .full_o    (hist_full)
   );

   irq_stuck_judge #(.TS_W(TS_W)) u_judge (
      .valid_i   (msg_valid_i),
      .full_i    (hist_full),
      .new_msg_i (in_msg),
      .new_ts_i  (time_i),
      .old_msg_i (old_msg),
      .old_ts_i  (old_ts),
      .thresh_i  (thresh_q),
      .hit_o     (hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thresh_q <= THR_RST;
         pulse_q  <= 1'b0;
         sticky_q <= 1'b0;
         latch_q  <= '0;
      end else begin
         if (thr_we_i) thresh_q <= thr_data_i;
         pulse_q <= hit;
         if (hit) latch_q <= in_msg;
         if (hit) sticky_q <= 1'b1;
         else if (stuck_clr_i) sticky_q <= 1'b0;
      end
   end

   assign stuck_pulse_o  = pulse_q;
   assign stuck_src_o    = latch_q.src;
   assign stuck_cause_o  = latch_q.cause;
   assign stuck_sticky_o = sticky_q;

   AST_PULSE_NEEDS_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stuck_pulse_o |-> $past(msg_valid_i)); // R9
   AST_PULSE_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stuck_pulse_o |-> $past(hist_full)); // R2
   AST_STICKY_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stuck_pulse_o |-> stuck_sticky_o); // R7
   AST_STICKY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stuck_sticky_o && !stuck_clr_i) |=> stuck_sticky_o); // R7
   AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stuck_pulse_o |-> ($stable(stuck_src_o) && $stable(stuck_cause_o))); // R10
   AST_ZERO_THR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thresh_q == '0) |=> !stuck_pulse_o); // R8

endmodule

// File: tb/irq_stuck_watch_tb.sv
module irq_stuck_watch_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [15:0] src = '0;
   logic [7:0]  cause = '0;
   logic [31:0] tim = '0;
   logic        thr_we = 1'b0;
   logic [31:0] thr_d = '0;
   logic        clr = 1'b0;
   logic        pulse;
   logic [15:0] s_src;
   logic [7:0]  s_cause;
   logic        sticky;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   irq_stuck_watch dut_i (
      .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(vld), .msg_src_i(src),
      .msg_cause_i(cause), .time_i(tim), .thr_we_i(thr_we), .thr_data_i(thr_d),
      .stuck_clr_i(clr), .stuck_pulse_o(pulse), .stuck_src_o(s_src),
      .stuck_cause_o(s_cause), .stuck_sticky_o(sticky)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      vld = 1'b0; clr = 1'b0; thr_we = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input logic [15:0] s, input logic [7:0] c,
                       input logic [31:0] t, output logic got);
      src = s; cause = c; tim = t; vld = 1'b1;
      @(negedge clk);
      got = pulse;
      vld = 1'b0;
   endtask

   task automatic set_thr(input logic [31:0] v);
      thr_d = v; thr_we = 1'b1;
      @(negedge clk);
      thr_we = 1'b0;
   endtask

   // sends n messages at t0, t0+step, ... and checks that none pulses
   task automatic fill(input logic [15:0] s, input logic [7:0] c,
                       input logic [31:0] t0, input logic [31:0] step, input int n);
      logic g;
      for (int i = 0; i < n; i++) begin
         send(s, c, t0 + step * i, g);
         chk("R2 no pulse while filling", g, 0);
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 pulse", pulse, 0);
      chk("R1 sticky", sticky, 0);
      chk("R1 src", s_src, 0);
      chk("R1 cause", s_cause, 0);
   endtask

   task automatic t_basic();
      logic g;
      do_reset();
      fill(16'h1234, 8'h05, 100, 1, 16);
      send(16'h1234, 8'h05, 116, g);
      chk("R3 17th matching message pulses", g, 1);
      chk("R6 latched src", s_src, 16'h1234);
      chk("R6 latched cause", s_cause, 8'h05);
      chk("R7 sticky set", sticky, 1);
      @(negedge clk);
      chk("R6 pulse lasts one cycle", pulse, 0);
      repeat (5) @(negedge clk);
      chk("R7 sticky holds", sticky, 1);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk("R7 sticky cleared", sticky, 0);
      chk("R10 src kept after clear", s_src, 16'h1234);
   endtask

   task automatic t_identity();
      logic g;
      do_reset();
      fill(16'h1234, 8'h05, 0, 1, 16);
      send(16'h1234, 8'h06, 16, g);
      chk("R3 cause differs", g, 0);
      send(16'h1235, 8'h05, 17, g);
      chk("R3 source differs", g, 0);
      send(16'h1234, 8'h05, 18, g);
      chk("R3 third oldest slot matches", g, 1);
      send(16'hBEEF, 8'h77, 19, g);
      chk("R10 src holds without hit", s_src, 16'h1234);
      chk("R10 cause holds without hit", s_cause, 8'h05);
   endtask

   task automatic t_thresh();
      logic g;
      do_reset();
      set_thr(50);
      fill(16'h00A0, 8'h01, 0, 10, 16);
      send(16'h00A0, 8'h01, 50, g);
      chk("R4 gap equal threshold", g, 0);
      send(16'h00A0, 8'h01, 59, g);
      chk("R4 gap threshold-1", g, 1);
   endtask

   task automatic t_default_thr();
      logic g;
      do_reset();
      fill(16'h0777, 8'h22, 0, 1, 16);
      send(16'h0777, 8'h22, 1024, g);
      chk("R8 reset threshold gap 1024", g, 0);
      send(16'h0777, 8'h22, 1024, g);
      chk("R8 reset threshold gap 1023", g, 1);
   endtask

   task automatic t_zero_thr();
      logic g;
      do_reset();
      set_thr(0);
      fill(16'h0001, 8'h01, 0, 0, 16);
      send(16'h0001, 8'h01, 0, g);
      chk("R8 zero threshold disables", g, 0);
   endtask

   task automatic t_wrap();
      logic g;
      do_reset();
      fill(16'h4321, 8'h09, 32'hFFFF_FFF0, 1, 16);
      send(16'h4321, 8'h09, 32'h0000_0005, g);
      chk("R5 short gap across wrap", g, 1);
      send(16'h4321, 8'h09, 32'h0000_1000, g);
      chk("R5 long gap across wrap", g, 0);
   endtask

   task automatic t_idle();
      logic g;
      do_reset();
      fill(16'h0055, 8'h03, 0, 1, 15);
      for (int i = 0; i < 20; i++) begin
         src = 16'(i * 7); cause = 8'(i); tim = 32'(i);
         @(negedge clk);
      end
      send(16'h0055, 8'h03, 15, g);
      chk("R9 idle cycles not stored", g, 0);
      clr = 1'b1;
      send(16'h0055, 8'h03, 16, g);
      clr = 1'b0;
      chk("R9 detection after idle", g, 1);
      chk("R7 set wins over clear", sticky, 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      t_reset();
      t_basic();
      t_identity();
      t_thresh();
      t_default_thr();
      t_zero_thr();
      t_wrap();
      t_idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule